// File: doc/BRIEF.md
# Input Macrocell Bank

This block is the input stage of one 8-bit I/O port on a programmable-logic front end. There is one macrocell for each port pin. Each macrocell passes one value to the logic-array input bus. A static two-bit mode per cell selects that value from three sources:

- the live pin value;
- a value caught by a register on a rising edge of a control;
- a value held by a transparent latch.

Two kinds of control exist. The first is a product-term control. There is one such control per group of four cells. Cells 0–3 share one and cells 4–7 share the other. The second is the host address-latch-enable (ALE) strobe, which can serve as the latch gate in place of the product-term control.

The whole block runs on one system clock with a synchronous active-high reset. Edges and levels of the controls are seen at that clock. A host reads all eight cell states as one byte at a fixed register offset. The offset depends on which port the instance serves: port A, B or C. On port C, four bits belong to test-access pins. Those bits return a fixed fill value, set by a parameter.

The read port is a plain strobe-and-response pair. It has no ready signal and applies no back-pressure. A read is accepted on every clock edge where it is presented. Its response valid rises exactly one cycle later and lasts one cycle.

Top module: `imc_bank`

## Requirements
- R1: A cell in mode 00 drives its pin value onto `to_array` combinationally, in the same cycle.
- R2: A cell in mode 01 loads its pin value at the clock edge where its group control is high and was low at the previous edge. The loaded value appears on `to_array` after that edge. The cell holds the value at every other edge.
- R3: A cell in mode 10 follows its pin while its group control is high. While the control is low, the cell shows the pin value sampled at the last clock edge where the control was high.
- R4: A cell in mode 11 behaves as in R3, with the `ale` input as its gate.
- R5: Cells 0–3 respond only to `grp_ctrl[0]`, and cells 4–7 respond only to `grp_ctrl[1]`. An edge on one group's control leaves the other group's stored values unchanged.
- R6: A clock edge with `rst` high clears every stored register value, latch value and control history to 0.
- R7: A read request loads a pending response at a clock edge. A read request means `rd_en` is high and `rd_addr` equals the port offset. After that edge, `rd_valid` is 1 for one cycle. During that cycle, `rd_data` bit n shows the current `to_array` bit n, where 1 means logic high.
- R8: When no read hit was seen at the last edge, `rd_valid` is 0 and `rd_data` is 0.
- R9: The port offset is 0x0A for PORT_ID 0, 0x0B for PORT_ID 1 and 0x18 for PORT_ID 2 (the default). Other addresses do not hit.
- R10: With PORT_ID 2, `rd_data` bits 0, 1, 5 and 6 always read TEST_PIN_VAL, whatever the cell state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 8 | Pin values, bit n to cell n |
| cell_mode | input | 16 | Static modes, bits [2n+1:2n] for cell n: 00 pass, 01 register, 10 product-term latch, 11 ALE latch |
| grp_ctrl | input | 2 | Product-term clock/gate, bit g for cells 4g..4g+3 |
| ale | input | 1 | Host address-latch-enable strobe |
| to_array | output | 8 | Cell outputs to the logic-array input bus |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read offset |
| rd_valid | output | 1 | Read response valid, one cycle after a hit |
| rd_data | output | 8 | Cell state byte while `rd_valid` is high, else 0 |

## Verification
A wrong stored value in a register-mode cell reaches `to_array` at the edge where it is loaded. It then stays there until the next rising group control, so a check made before that control rises again sees it.

A latch that holds the wrong value, or latches on the wrong gate, shows the error in the first cycle its gate is low. A miswired group index shows up as a stored value changing after the other group's edge.

A bad offset, a mask or a missing reset shows up in the first read response or in the first cycle after reset.

// File: rtl/imc_pkg.sv
package imc_pkg;

  typedef enum logic [1:0] {
    IMC_PASS   = 2'b00,
    IMC_PTREG  = 2'b01,
    IMC_PTLAT  = 2'b10,
    IMC_ALELAT = 2'b11
  } imc_mode_e;

  // Register offset of the cell-state byte for each port
  function automatic logic [7:0] port_offset(input int port_id);
    case (port_id)
      0:       return 8'h0A;
      1:       return 8'h0B;
      default: return 8'h18;
    endcase
  endfunction

  // Bits that read a fixed value (test-access pins, port C only)
  function automatic logic [31:0] testpin_mask(input int port_id);
    if (port_id == 2) return 32'h0000_0063;
    return 32'h0;
  endfunction

endpackage

// File: rtl/imc_grp_edge.sv
module imc_grp_edge #(
  parameter int N_GROUPS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_GROUPS-1:0] ctrl,
  output logic [N_GROUPS-1:0] rise
);

  logic [N_GROUPS-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl;
  end

  genvar g;
  generate
    for (g = 0; g < N_GROUPS; g++) begin : g_rise
      assign rise[g] = ctrl[g] & ~ctrl_q[g];

      // R2: a rise is flagged only when the control was low one edge earlier
      assert_rise_after_low_R2: assert property (@(posedge clk) disable iff (rst)
        rise[g] |-> !$past(ctrl[g]));
    end
  endgenerate

  // R6: reset clears control history
  assert_hist_clear_R6: assert property (@(posedge clk) rst |=> ctrl_q == '0);

endmodule

// File: rtl/imc_cell.sv
module imc_cell
  import imc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  imc_mode_e mode,
  input  logic      pin_in,
  input  logic      pt_ctrl,
  input  logic      pt_rise,
  input  logic      ale,
  output logic      cell_out
);

  logic reg_q;
  logic hold_q;
  logic gate;

  always_comb gate = (mode == IMC_ALELAT) ? ale : pt_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (pt_rise) reg_q  <= pin_in;
      if (gate)    hold_q <= pin_in;
    end
  end

  always_comb begin
    unique case (mode)
      IMC_PASS:   cell_out = pin_in;
      IMC_PTREG:  cell_out = reg_q;
      default:    cell_out = gate ? pin_in : hold_q;
    endcase
  end

  // R2: captured value shows after the rising control
  assert_reg_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == IMC_PTREG && pt_rise) |=> (mode != IMC_PTREG || cell_out == $past(pin_in)));

  // R2: no rise, no change
  assert_reg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == IMC_PTREG && !pt_rise) |=> (mode != IMC_PTREG || $stable(cell_out)));

  // R3: closing product-term latch keeps last open-cycle sample
  assert_ptlat_close_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == IMC_PTLAT && pt_ctrl) ##1 (mode == IMC_PTLAT && !pt_ctrl)
      |-> cell_out == $past(pin_in));

  // R4: same for the ALE-gated latch
  assert_alelat_close_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == IMC_ALELAT && ale) ##1 (mode == IMC_ALELAT && !ale)
      |-> cell_out == $past(pin_in));

  // R6: stored values cleared by reset
  assert_store_clear_R6: assert property (@(posedge clk)
    rst |=> (reg_q == 1'b0 && hold_q == 1'b0));

endmodule

// File: rtl/imc_readback.sv
module imc_readback #(
  parameter int              N_CELLS = 8,
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0]  OFFSET = '0,
  parameter logic [N_CELLS-1:0] FIXED_MASK = '0,
  parameter logic            FILL_VAL = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [N_CELLS-1:0] cell_state,
  output logic               rd_valid,
  output logic [N_CELLS-1:0] rd_data
);

  localparam logic [N_CELLS-1:0] FILL_BITS = FILL_VAL ? FIXED_MASK : '0;

  logic hit_q;
  logic hit_now;

  always_comb hit_now = rd_en && (rd_addr == OFFSET);

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit_now;
  end

  assign rd_valid = hit_q;
  assign rd_data  = hit_q ? ((cell_state & ~FIXED_MASK) | FILL_BITS) : '0;

  // R7: a hit is answered on the next cycle
  assert_rd_answer_R7: assert property (@(posedge clk) disable iff (rst)
    hit_now |=> rd_valid);

  // R8: no hit, quiet response
  assert_rd_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !hit_now |=> (!rd_valid && rd_data == '0));

  // R10: fixed bits read the fill value
  assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rd_data & FIXED_MASK) == FILL_BITS));

endmodule

// File: rtl/imc_bank.sv
module imc_bank
  import imc_pkg::*;
#(
  parameter int   N_CELLS      = 8,
  parameter int   GROUP_SIZE   = 4,
  parameter int   ADDR_W       = 8,
  parameter int   PORT_ID      = 2,
  parameter logic TEST_PIN_VAL = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_CELLS-1:0]           pin_in,
  input  logic [2*N_CELLS-1:0]         cell_mode,
  input  logic [N_CELLS/GROUP_SIZE-1:0] grp_ctrl,
  input  logic                         ale,
  output logic [N_CELLS-1:0]           to_array,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic                         rd_valid,
  output logic [N_CELLS-1:0]           rd_data
);

  localparam int N_GROUPS = N_CELLS / GROUP_SIZE;
  localparam logic [ADDR_W-1:0]  OFFSET = ADDR_W'(port_offset(PORT_ID));
  localparam logic [31:0]        MASK32 = testpin_mask(PORT_ID);
  localparam logic [N_CELLS-1:0] FIXED_MASK = MASK32[N_CELLS-1:0];

  logic [N_GROUPS-1:0] grp_rise;

  imc_grp_edge #(.N_GROUPS(N_GROUPS)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .ctrl (grp_ctrl),
    .rise (grp_rise)
  );

  genvar i;
  generate
    for (i = 0; i < N_CELLS; i++) begin : g_cell
      localparam int GRP = i / GROUP_SIZE;

      imc_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .mode     (imc_mode_e'(cell_mode[2*i +: 2])),
        .pin_in   (pin_in[i]),
        .pt_ctrl  (grp_ctrl[GRP]),
        .pt_rise  (grp_rise[GRP]),
        .ale      (ale),
        .cell_out (to_array[i])
      );
    end
  endgenerate

  imc_readback #(
    .N_CELLS    (N_CELLS),
    .ADDR_W     (ADDR_W),
    .OFFSET     (OFFSET),
    .FIXED_MASK (FIXED_MASK),
    .FILL_VAL   (TEST_PIN_VAL)
  ) u_rb (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .cell_state (to_array),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

endmodule

// File: tb/imc_bank_bench.sv
`timescale 1ns/100ps
module imc_bank_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] pin_in;
  logic [15:0] cell_mode;
  logic [1:0] grp_ctrl;
  logic       ale;
  logic [7:0] to_array;
  logic       rd_en;
  logic [7:0] rd_addr;
  logic       rd_valid;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  imc_bank u_imc_bank (
    .clk (clk), .rst (rst), .pin_in (pin_in), .cell_mode (cell_mode),
    .grp_ctrl (grp_ctrl), .ale (ale), .to_array (to_array),
    .rd_en (rd_en), .rd_addr (rd_addr), .rd_valid (rd_valid), .rd_data (rd_data)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] pin;
    logic [1:0] ctl;
    logic       ale;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  // Modes: c7=11 c6=00 c5=10 c4=01 c3=11 c2=10 c1=01 c0=00
  localparam logic [15:0] MIX_CFG = 16'hC9E4;

  localparam vec_t VECS [11] = '{
    '{8'hFF, 2'b00, 1'b0, 8'h41, 4'd1},  // R1 pass cells follow pin
    '{8'hFF, 2'b01, 1'b0, 8'h45, 4'd3},  // R3 open latch transparent
    '{8'h00, 2'b01, 1'b0, 8'h02, 4'd2},  // R2 capture visible after rise
    '{8'hFF, 2'b00, 1'b1, 8'hCB, 4'd4},  // R4 ALE latch open, R3 hold
    '{8'h00, 2'b10, 1'b0, 8'h8A, 4'd4},  // R4 ALE latch holds
    '{8'hFF, 2'b10, 1'b0, 8'hEB, 4'd2},  // R2 no new rise, no load
    '{8'h00, 2'b00, 1'b0, 8'hAA, 4'd3},  // R3 closed latch holds 1
    '{8'hFF, 2'b10, 1'b0, 8'hEB, 4'd2},  // R2 new rise on group 1
    '{8'h00, 2'b00, 1'b0, 8'hBA, 4'd5},  // R5 group 0 reg untouched
    '{8'h00, 2'b01, 1'b0, 8'hBA, 4'd5},  // R5 group 0 rise
    '{8'h00, 2'b00, 1'b0, 8'hB8, 4'd5}   // R5 cell4 kept, cell1 reloaded
  };

  initial begin
    rst = 1'b1; pin_in = '0; cell_mode = MIX_CFG; grp_ctrl = '0; ale = 1'b0;
    rd_en = 1'b0; rd_addr = '0;
    repeat (2) @(negedge clk);
    #1;
    check8("R6 reset out", to_array, 8'h00);
    check8("R8 reset rd_valid", {7'b0, rd_valid}, 8'h00);
    rst = 1'b0;

    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      pin_in = VECS[k].pin; grp_ctrl = VECS[k].ctl; ale = VECS[k].ale;
      #1;
      check8($sformatf("R%0d step %0d", VECS[k].req, k), to_array, VECS[k].exp);
    end

    // R6: reset wipes stored 0xB8 state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check8("R6 after reset", to_array, 8'h00);

    // R1: pass-through with live pin change
    cell_mode = 16'h0000; pin_in = 8'h3C; #1;
    check8("R1 live pass", to_array, 8'h3C);

    // R7 / R9 / R10: read at port C offset
    pin_in = 8'hFF; rd_en = 1'b1; rd_addr = 8'h18;
    @(negedge clk); #1;
    check8("R7 rd_valid", {7'b0, rd_valid}, 8'h01);
    check8("R10 masked byte", rd_data, 8'h9C);
    pin_in = 8'h5A; #1;
    check8("R7 live state", rd_data, 8'h18);
    rd_addr = 8'h0A;
    @(negedge clk); #1;
    check8("R8 miss valid", {7'b0, rd_valid}, 8'h00);
    check8("R8 miss data", rd_data, 8'h00);
    rd_addr = 8'h0B;
    @(negedge clk); #1;
    check8("R9 other offset", {7'b0, rd_valid}, 8'h00);
    rd_en = 1'b0; rd_addr = 8'h18;
    @(negedge clk); #1;
    check8("R8 no strobe", {7'b0, rd_valid}, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule